// File: doc/BRIEF.md
# Packed SIMD Shift and Add Unit

A combinational execute unit for a packed-SIMD extension on a 32-bit datapath. It takes a decoded operation, the destination and source register indices, two 32-bit operand values, a 4-bit immediate and a 2-bit mode, and it returns a packed 32-bit result together with an illegal-encoding flag. The lane width is not encoded in the operation. It comes from the register range the indices fall in: low registers select four 8-bit lanes, and high registers select two 16-bit lanes. Each lane is computed on its own, with no carry or shifted bit crossing a lane edge.

The unit covers wrapping add, signed halving add, and three shifts: arithmetic right, logical right and left. Each shift takes its amount either from the matching lane of the second operand or from the immediate. Mode 01 turns the right shifts into rounding shifts and the left shift into a signed saturating shift. Any encoding the unit does not accept raises the illegal flag and forces the result to zero.

Top module: `simd_shift_add`

## Requirements
- R1: When rd_i, rs1_i and every source register in use all lie in 2..15, the result is four independent 8-bit lanes (lane k in bits 8k+7:8k).
- R2: When rd_i, rs1_i and every source register in use all lie in 16..29, the result is two independent 16-bit lanes (lane k in bits 16k+15:16k).
- R3: illegal_o is 1 when any register in use is 0, 1, 30 or 31, or when the registers in use mix the 2..15 and 16..29 ranges. rs2_i is in use only when use_imm_i is 0.
- R4: Signed halving add (op_i=1) is legal only if all registers in use lie in 2..7 (8-bit lanes) or in 16..23 (16-bit lanes).
- R5: op_i=0 with mode 00 gives the wrapping sum of each lane.
- R6: op_i=1 gives floor((a+b)/2) of each signed lane, computed without overflow.
- R7: With mode 00, op_i=2 is an arithmetic right shift, op_i=3 a logical right shift and op_i=4 a left shift, all truncating. The amount is the low 3 bits (8-bit lanes) or low 4 bits (16-bit lanes) of the src_b_i lane when use_imm_i=0, and of imm_i when use_imm_i=1.
- R8: Mode 01 on op_i=2 or 3 adds bit (amount-1) of the input lane to the shifted lane. An amount of zero returns the lane unchanged.
- R9: Mode 01 on op_i=4 treats lanes as signed and clamps to the largest or smallest lane value whenever the shifted value does not fit.
- R10: illegal_o is 1 for op_i values 5..7, for mode_i 10 or 11, for mode 01 on op_i 0 or 1, and for use_imm_i=1 on op_i 0 or 1.
- R11: Whenever illegal_o is 1, result_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation: 0 add, 1 halving add, 2 arith right, 3 logic right, 4 left shift |
| use_imm_i | input | 1 | Shift amount from imm_i instead of src_b_i |
| rd_i | input | 5 | Destination register index |
| rs1_i | input | 5 | First source register index |
| rs2_i | input | 5 | Second source register index |
| src_a_i | input | 32 | First operand value |
| src_b_i | input | 32 | Second operand value |
| imm_i | input | 4 | Immediate shift amount |
| mode_i | input | 2 | 00 plain, 01 rounding or saturating |
| result_o | output | 32 | Packed result |
| illegal_o | output | 1 | Encoding not accepted |

## Verification
The assertions assume the inputs are stable, settled values whenever they are evaluated. They also assume that an immediate shift with a zero amount and a legal register set must pass the operand through unchanged, whatever the mode. The stimulus changes all inputs together once per clock, shortly after the rising edge, and compares the outputs on the falling edge. Register indices are picked at the range edges (1, 2, 7, 8, 15, 16, 23, 24, 29, 30) so that each legality boundary is crossed from both sides.

// File: rtl/simd_pkg.sv
`timescale 1ns/1ps
package simd_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_HADD = 3'd1,
    OP_SRA  = 3'd2,
    OP_SRL  = 3'd3,
    OP_SLL  = 3'd4
  } simd_op_e;

  localparam logic [1:0] MODE_PLAIN = 2'b00;
  localparam logic [1:0] MODE_ALT   = 2'b01;
endpackage

// File: rtl/simd_reg_group.sv
`timescale 1ns/1ps
module simd_reg_group #(
  parameter int REG_W = 5,
  parameter int LO    = 2,
  parameter int HI    = 15,
  parameter int HI_N  = 7
) (
  input  logic [REG_W-1:0] rd_i,
  input  logic [REG_W-1:0] rs1_i,
  input  logic [REG_W-1:0] rs2_i,
  input  logic             use_rs2_i,
  input  logic             narrow_i,
  output logic             in_grp_o
);
  logic [REG_W-1:0] top_idx;
  logic rd_ok, rs1_ok, rs2_ok;

  assign top_idx = narrow_i ? REG_W'(HI_N) : REG_W'(HI);
  assign rd_ok   = (rd_i  >= REG_W'(LO)) && (rd_i  <= top_idx);
  assign rs1_ok  = (rs1_i >= REG_W'(LO)) && (rs1_i <= top_idx);
  assign rs2_ok  = (rs2_i >= REG_W'(LO)) && (rs2_i <= top_idx);
  assign in_grp_o = rd_ok && rs1_ok && (!use_rs2_i || rs2_ok);
endmodule

// File: rtl/simd_lane_alu.sv
`timescale 1ns/1ps
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int W  = 8,
  localparam int AW = $clog2(W)
) (
  input  logic [2:0]    op_i,
  input  logic          alt_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  y_o
);
  logic [W:0]     hsum;
  logic [W-1:0]   sra_t, srl_t, sat_v;
  logic [2*W-1:0] wide;
  logic           rbit, fits;

  assign hsum  = {a_i[W-1], a_i} + {b_i[W-1], b_i};
  assign sra_t = W'($signed(a_i) >>> amt_i);
  assign srl_t = a_i >> amt_i;
  // last bit shifted out; zero amount shifts nothing out
  assign rbit  = (amt_i == '0) ? 1'b0 : a_i[amt_i - AW'(1)];
  assign wide  = {{W{a_i[W-1]}}, a_i} << amt_i;
  assign fits  = (&wide[2*W-1:W-1]) || !(|wide[2*W-1:W-1]);
  assign sat_v = a_i[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};

  always_comb begin
    unique case (simd_op_e'(op_i))
      OP_ADD:  y_o = a_i + b_i;
      OP_HADD: y_o = hsum[W:1];
      OP_SRA:  y_o = sra_t + W'(alt_i & rbit);
      OP_SRL:  y_o = srl_t + W'(alt_i & rbit);
      OP_SLL:  y_o = (alt_i && !fits) ? sat_v : wide[W-1:0];
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_shift_add.sv
`timescale 1ns/1ps
module simd_shift_add
  import simd_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int REG_W   = 5,
  parameter int NAR_W   = 8,
  parameter int WID_W   = 16,
  parameter int NAR_LO  = 2,
  parameter int NAR_HI  = 15,
  parameter int NAR_HN  = 7,
  parameter int WID_LO  = 16,
  parameter int WID_HI  = 29,
  parameter int WID_HN  = 23,
  localparam int IMM_W  = $clog2(WID_W)
) (
  input  logic [2:0]       op_i,
  input  logic             use_imm_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic [REG_W-1:0] rs1_i,
  input  logic [REG_W-1:0] rs2_i,
  input  logic [XLEN-1:0]  src_a_i,
  input  logic [XLEN-1:0]  src_b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [1:0]       mode_i,
  output logic [XLEN-1:0]  result_o,
  output logic             illegal_o
);
  logic            is_add, is_shift, op_ok, mode_ok, imm_ok, narrow;
  logic [1:0]      grp;
  logic [XLEN-1:0] res_w [2];

  assign is_add   = (op_i == OP_ADD) || (op_i == OP_HADD);
  assign is_shift = (op_i == OP_SRA) || (op_i == OP_SRL) || (op_i == OP_SLL);
  assign op_ok    = is_add || is_shift;
  assign mode_ok  = (mode_i == MODE_PLAIN) || ((mode_i == MODE_ALT) && is_shift);
  assign imm_ok   = !use_imm_i || is_shift;
  assign narrow   = (op_i == OP_HADD);

  for (genvar w = 0; w < 2; w++) begin : g_width
    localparam int LW = (w == 0) ? NAR_W : WID_W;
    localparam int LN = XLEN / LW;
    localparam int AW = $clog2(LW);

    simd_reg_group #(
      .REG_W(REG_W),
      .LO   ((w == 0) ? NAR_LO : WID_LO),
      .HI   ((w == 0) ? NAR_HI : WID_HI),
      .HI_N ((w == 0) ? NAR_HN : WID_HN)
    ) u_grp (
      .rd_i     (rd_i),
      .rs1_i    (rs1_i),
      .rs2_i    (rs2_i),
      .use_rs2_i(!use_imm_i),
      .narrow_i (narrow),
      .in_grp_o (grp[w])
    );

    for (genvar l = 0; l < LN; l++) begin : g_lane
      logic [AW-1:0] amt;
      assign amt = use_imm_i ? imm_i[AW-1:0] : src_b_i[l*LW +: AW];

      simd_lane_alu #(.W(LW)) u_alu (
        .op_i (op_i),
        .alt_i(mode_i[0]),
        .a_i  (src_a_i[l*LW +: LW]),
        .b_i  (src_b_i[l*LW +: LW]),
        .amt_i(amt),
        .y_o  (res_w[w][l*LW +: LW])
      );
    end
  end

  assign illegal_o = !(op_ok && mode_ok && imm_ok && (grp[0] || grp[1]));
  assign result_o  = illegal_o ? '0 : (grp[1] ? res_w[1] : res_w[0]);
endmodule

// File: rtl/simd_shift_add_chk.sv
`timescale 1ns/1ps
module simd_shift_add_chk (
  input logic [2:0]  op_i,
  input logic        use_imm_i,
  input logic [4:0]  rd_i,
  input logic [4:0]  rs1_i,
  input logic [4:0]  rs2_i,
  input logic [31:0] src_a_i,
  input logic [31:0] src_b_i,
  input logic [3:0]  imm_i,
  input logic [1:0]  mode_i,
  input logic [31:0] result_o,
  input logic        illegal_o
);
  logic bad_idx;
  assign bad_idx = (rd_i < 5'd2) || (rd_i > 5'd29) || (rs1_i < 5'd2) || (rs1_i > 5'd29);

  always_comb begin
    p_zero_on_illegal_r11: assert (!illegal_o || result_o == '0)
      else $error("result not zero while illegal");
    p_bad_index_r3: assert (!bad_idx || illegal_o)
      else $error("reserved register accepted");
    p_mode_high_r10: assert (!mode_i[1] || illegal_o)
      else $error("mode 1x accepted");
    p_hadd_range_r4: assert (!(op_i == 3'd1 && rd_i >= 5'd8 && rd_i <= 5'd15) || illegal_o)
      else $error("halving add outside narrow range accepted");
    p_add_zero_r5: assert (!(op_i == 3'd0 && !illegal_o && src_b_i == '0) || result_o == src_a_i)
      else $error("adding zero changed operand");
    p_shift_zero_r8: assert (!((op_i == 3'd2 || op_i == 3'd3 || op_i == 3'd4) && use_imm_i
                               && imm_i == '0 && !illegal_o) || result_o == src_a_i)
      else $error("zero shift changed operand");
  end
endmodule

bind simd_shift_add simd_shift_add_chk u_chk (.*);

// File: tb/simd_shift_add_tb.sv
`timescale 1ns/1ps
module simd_shift_add_tb;
  typedef struct {
    logic [31:0] res;
    logic        ill;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic [2:0]  op_i = '0;
  logic        use_imm_i = 1'b0;
  logic [4:0]  rd_i = '0, rs1_i = '0, rs2_i = '0;
  logic [31:0] src_a_i = '0, src_b_i = '0;
  logic [3:0]  imm_i = '0;
  logic [1:0]  mode_i = '0;
  logic [31:0] result_o;
  logic        illegal_o;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  always #5 clk = ~clk;

  simd_shift_add u_dut (.*);

  function automatic bit inr(input logic [4:0] r, input int lo, input int hi);
    return (int'(r) >= lo) && (int'(r) <= hi);
  endfunction

  function automatic void model(input logic [2:0] op, input logic ui, input logic [4:0] rd,
                                input logic [4:0] r1, input logic [4:0] r2, input logic [31:0] a,
                                input logic [31:0] b, input logic [3:0] imm, input logic [1:0] md,
                                output logic [31:0] res, output logic ill);
    bit g8, g16, hv;
    int w, n;
    longint acc, mask, half, ua, ub, sa, sb, v, amt;
    hv  = (op == 3'd1);
    g8  = inr(rd, 2, hv ? 7 : 15) && inr(r1, 2, hv ? 7 : 15) && (ui || inr(r2, 2, hv ? 7 : 15));
    g16 = inr(rd, 16, hv ? 23 : 29) && inr(r1, 16, hv ? 23 : 29) && (ui || inr(r2, 16, hv ? 23 : 29));
    ill = (op > 3'd4) || md[1] || (md == 2'b01 && op < 3'd2) || (ui && op < 3'd2) || !(g8 || g16);
    res = '0;
    if (ill) return;
    w = g16 ? 16 : 8;
    n = 32 / w;
    mask = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    acc = 0;
    for (int i = 0; i < n; i++) begin
      ua = (longint'(a) >> (i * w)) & mask;
      ub = (longint'(b) >> (i * w)) & mask;
      sa = (ua >= half) ? ua - (mask + 1) : ua;
      sb = (ub >= half) ? ub - (mask + 1) : ub;
      amt = ui ? (longint'(imm) & (w - 1)) : (ub & (w - 1));
      case (op)
        3'd0: v = ua + ub;
        3'd1: v = (sa + sb) >>> 1;
        3'd2: begin
          v = sa >>> amt;
          if (md == 2'b01 && amt > 0) v += (sa >>> (amt - 1)) & 1;
        end
        3'd3: begin
          v = ua >> amt;
          if (md == 2'b01 && amt > 0) v += (ua >> (amt - 1)) & 1;
        end
        default: begin
          v = sa * (longint'(1) << amt);
          if (md == 2'b01) begin
            if (v > half - 1) v = half - 1;
            if (v < -half) v = -half;
          end
        end
      endcase
      acc |= (v & mask) << (i * w);
    end
    res = 32'(acc);
  endfunction

  task automatic drive(input logic [2:0] op, input logic ui, input logic [4:0] rd,
                       input logic [4:0] r1, input logic [4:0] r2, input logic [31:0] a,
                       input logic [31:0] b, input logic [3:0] imm, input logic [1:0] md,
                       input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    op_i = op; use_imm_i = ui; rd_i = rd; rs1_i = r1; rs2_i = r2;
    src_a_i = a; src_b_i = b; imm_i = imm; mode_i = md;
    model(op, ui, rd, r1, r2, a, b, imm, md, e.res, e.ill);
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (result_o !== e.res || illegal_o !== e.ill) begin
        n_err++;
        $display("FAIL %s: got res=%08h ill=%0b expected res=%08h ill=%0b",
                 e.tag, result_o, illegal_o, e.res, e.ill);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // reset-like idle state: all-zero inputs use register 0
    drive(3'd0, 0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h0, 4'd0, 2'b00, "R3 idle");
    // R1 / R5 8-bit wrap per lane
    drive(3'd0, 0, 5'd2, 5'd15, 5'd9, 32'hFF80_7F01, 32'h0180_01FF, 4'd0, 2'b00, "R1 R5 add8");
    // R2 / R5 16-bit lanes, carry must cross 8-bit boundary
    drive(3'd0, 0, 5'd16, 5'd29, 5'd20, 32'h00FF_FFFF, 32'h0001_0001, 4'd0, 2'b00, "R2 R5 add16");
    // R6 halving add
    drive(3'd1, 0, 5'd2, 5'd7, 5'd3, 32'h7F80_FF03, 32'h7F80_FE04, 4'd0, 2'b00, "R6 hadd8");
    drive(3'd1, 0, 5'd16, 5'd23, 5'd17, 32'h7FFF_8000, 32'h7FFF_FFFF, 4'd0, 2'b00, "R6 hadd16");
    // R4 narrow range edges
    drive(3'd1, 0, 5'd8, 5'd2, 5'd2, 32'h1, 32'h1, 4'd0, 2'b00, "R4 hadd r8");
    drive(3'd1, 0, 5'd16, 5'd24, 5'd16, 32'h1, 32'h1, 4'd0, 2'b00, "R4 hadd r24");
    // R3 straddle and reserved
    drive(3'd0, 0, 5'd15, 5'd16, 5'd2, 32'h1, 32'h1, 4'd0, 2'b00, "R3 straddle");
    drive(3'd0, 0, 5'd2, 5'd2, 5'd1, 32'h1, 32'h1, 4'd0, 2'b00, "R3 rs2=1");
    drive(3'd2, 0, 5'd30, 5'd16, 5'd16, 32'h1, 32'h1, 4'd0, 2'b00, "R3 rd=30");
    drive(3'd2, 1, 5'd16, 5'd29, 5'd31, 32'h8000_4000, 32'h0, 4'd3, 2'b00, "R3 imm ignores rs2");
    // R7 register-form shifts, amounts from lane low bits
    drive(3'd2, 0, 5'd4, 5'd5, 5'd6, 32'h80F0_7F11, 32'h0709_0301, 4'd0, 2'b00, "R7 sra8");
    drive(3'd3, 0, 5'd4, 5'd5, 5'd6, 32'h80F0_7F11, 32'h0709_0301, 4'd0, 2'b00, "R7 srl8");
    drive(3'd4, 0, 5'd4, 5'd5, 5'd6, 32'h80F0_7F11, 32'h0709_0301, 4'd0, 2'b00, "R7 sll8");
    drive(3'd2, 1, 5'd18, 5'd19, 5'd0, 32'h8001_7FFF, 32'h0, 4'd15, 2'b00, "R7 srai16");
    drive(3'd4, 1, 5'd10, 5'd11, 5'd0, 32'h0102_0304, 32'h0, 4'd12, 2'b00, "R7 slli8 uses low3");
    // R8 rounding
    drive(3'd2, 0, 5'd20, 5'd21, 5'd22, 32'hFFFF_0003, 32'h0001_0001, 4'd0, 2'b01, "R8 rsra16");
    drive(3'd3, 1, 5'd3, 5'd3, 5'd0, 32'hFF07_0602, 32'h0, 4'd1, 2'b01, "R8 rsrli8");
    drive(3'd2, 1, 5'd3, 5'd3, 5'd0, 32'h8123_45FF, 32'h0, 4'd0, 2'b01, "R8 zero amount");
    drive(3'd3, 0, 5'd3, 5'd3, 5'd4, 32'h7F81_FFC3, 32'h0307_0602, 4'd0, 2'b01, "R8 rsrl8 reg");
    // R9 saturation
    drive(3'd4, 0, 5'd12, 5'd13, 5'd14, 32'h40C0_BF01, 32'h0101_0107, 4'd0, 2'b01, "R9 ssll8");
    drive(3'd4, 1, 5'd28, 5'd28, 5'd0, 32'h0FFF_F000, 32'h0, 4'd4, 2'b01, "R9 sslli16 edge");
    drive(3'd4, 1, 5'd28, 5'd28, 5'd0, 32'h1000_EFFF, 32'h0, 4'd4, 2'b01, "R9 sslli16 clamp");
    // R10 unsupported encodings
    drive(3'd0, 0, 5'd2, 5'd2, 5'd2, 32'h5, 32'h5, 4'd0, 2'b01, "R10 add mode01");
    drive(3'd2, 0, 5'd2, 5'd2, 5'd2, 32'h5, 32'h5, 4'd0, 2'b10, "R10 mode10");
    drive(3'd5, 0, 5'd2, 5'd2, 5'd2, 32'h5, 32'h5, 4'd0, 2'b00, "R10 op5");
    drive(3'd0, 1, 5'd2, 5'd2, 5'd0, 32'h5, 32'h5, 4'd0, 2'b00, "R10 R11 add imm");
    drive(3'd7, 0, 5'd16, 5'd16, 5'd16, 32'hFFFF_FFFF, 32'h1, 4'd0, 2'b11, "R11 op7 zero");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule